// File: doc/BRIEF.md
# Exception PC and Trap-Vector Unit

This unit keeps the machine exception program counter and works out where fetch goes when a trap is taken. Software reaches the register through a plain CSR port: a write strobe with write data, and a read value. Address decoding happens outside. When the pipeline takes a trap it presents the faulting PC on the trap-entry port, and the register captures it at the next clock edge. A trap-entry capture takes priority over a CSR write in the same cycle. The trap-return path reads the same register through a dedicated output. That output uses the same alignment masking as a CSR read, so the address handed to fetch is always legal.

Two alignment configurations are supported. In the fixed configuration only 32-bit instruction alignment exists, and the two low bits always read as zero. In the switchable configuration an input selects 16-bit or 32-bit alignment. Under 32-bit alignment, bit 1 is hidden on every read but stays stored, and it becomes visible again when 16-bit alignment returns. Bit 0 never holds a one in either configuration.

The trap-target output is combinational. It takes the trap-vector register value, with its two low mode bits, plus the trap kind and cause. Synchronous exceptions always jump to the vector base with the mode bits cleared. Interrupts under vectored mode add four times the cause number to that base.

Top module: `epc_trap_unit`

## Requirements
- R1: While reset is asserted and directly after it, both the CSR read value and the return PC are zero.
- R2: Bit 0 of the CSR read value and of the return PC is zero for any written or captured value.
- R3: In the switchable configuration, bit 1 of the read value and the return PC is zero while `align32` is 1, and it shows the stored bit while `align32` is 0.
- R4: Bit 1 written or captured while `align32` is 1 stays stored. Clearing `align32` later, with no further write, makes it visible.
- R5: In the fixed configuration (`ALIGN_SWITCHABLE` = 0), bits 1:0 of the read value and the return PC are always zero, whatever `align32` is.
- R6: `ret_pc` always equals `csr_rdata`.
- R7: When `trap_take` is high at a rising edge, `trap_pc` (with its low bit dropped) becomes the register value after that edge.
- R8: When `trap_take` and `csr_we` are both high at one edge, the value from `trap_pc` is stored and `csr_wdata` is discarded.
- R9: For a synchronous exception (`trap_irq` = 0), `trap_target` equals `tvec` with bits 1:0 cleared, whatever the mode in `tvec[1:0]`.
- R10: For an interrupt with `tvec[1:0]` = 2'b01 (vectored), `trap_target` equals the cleared base plus 4 × `trap_cause`, including the largest cause value.
- R11: For an interrupt with `tvec[1:0]` of 2'b00, 2'b10 or 2'b11, `trap_target` equals the cleared base.
- R12: With neither `csr_we` nor `trap_take` high, the stored value is kept across edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe for the exception PC |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Masked CSR read value |
| trap_take | input | 1 | Trap entry; capture `trap_pc` this edge |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_irq | input | 1 | 1 if the trap is an interrupt |
| trap_cause | input | CAUSE_W | Cause number of the trap |
| tvec | input | XLEN | Trap-vector register value, mode in bits 1:0 |
| align32 | input | 1 | 1 selects 32-bit instruction alignment |
| ret_pc | output | XLEN | Return PC for the trap-return instruction |
| trap_target | output | XLEN | PC to fetch from on trap entry |

## Verification
The embedded properties assume that every input has a known value whenever reset is released. They also assume that `csr_we` and `trap_take` may be high together, and that `align32` may change in any cycle, even on the edge that writes the register. The bench keeps to these assumptions. It drives every input from the falling clock edge, holds the strobes for exactly one rising edge, and changes `align32` only between writes or together with them. It then samples the combinational outputs one nanosecond after the following falling edge.

// File: rtl/epc_pkg.sv
package epc_pkg;

    // Encodings of the trap-vector mode field (tvec[1:0])
    localparam logic [1:0] TVEC_MODE_DIRECT   = 2'b00;
    localparam logic [1:0] TVEC_MODE_VECTORED = 2'b01;

    // Byte distance between consecutive interrupt vector slots (log2)
    localparam int unsigned VEC_SLOT_SHIFT = 2;

endpackage

// File: rtl/epc_store.sv
module epc_store #(
    parameter int unsigned XLEN             = 32,
    parameter bit          ALIGN_SWITCHABLE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            trap_take,
    input  logic [XLEN-1:0] trap_pc,
    output logic [XLEN-1:0] epc_raw
);

    // Bits the register can hold: bit 0 never; bit 1 only if 16-bit mode exists
    localparam logic [XLEN-1:0] HOLD_MASK_SW  = ~XLEN'(1);
    localparam logic [XLEN-1:0] HOLD_MASK_FIX = ~XLEN'(3);

    typedef struct packed {
        logic [XLEN-1:0] epc;
    } store_t;

    store_t          st_d, st_q;
    logic [XLEN-1:0] hold_mask;

    generate
        if (ALIGN_SWITCHABLE) begin : g_sw
            assign hold_mask = HOLD_MASK_SW;
        end else begin : g_fix
            assign hold_mask = HOLD_MASK_FIX;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (trap_take) begin
            st_d.epc = trap_pc & hold_mask;
        end else if (csr_we) begin
            st_d.epc = csr_wdata & hold_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign epc_raw = st_q.epc;

    // R7: a trap entry captures the faulting PC
    a_r7_trap_capture: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (epc_raw == ($past(trap_pc) & hold_mask)));

    // R8: a simultaneous CSR write loses to trap entry
    a_r8_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && csr_we && (trap_pc != csr_wdata)) |=>
            (epc_raw != ($past(csr_wdata) & hold_mask)) || ($past(trap_pc) & hold_mask) == ($past(csr_wdata) & hold_mask));

    // R12: no strobe means no change
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_take && !csr_we) |=> $stable(epc_raw));

    // R2: stored state never carries an odd address
    a_r2_no_odd_store: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> !epc_raw[0]);

endmodule

// File: rtl/epc_read_mask.sv
module epc_read_mask #(
    parameter int unsigned XLEN             = 32,
    parameter bit          ALIGN_SWITCHABLE = 1'b1
) (
    input  logic [XLEN-1:0] epc_raw,
    input  logic            align32,
    output logic [XLEN-1:0] epc_vis
);

    logic hide_bit1;

    generate
        if (ALIGN_SWITCHABLE) begin : g_sw
            // Bit 1 is hidden only while 32-bit alignment is selected
            assign hide_bit1 = align32;
        end else begin : g_fix
            // Only 32-bit alignment exists: bit 1 is always hidden
            assign hide_bit1 = 1'b1 | align32;
        end
    endgenerate

    always_comb begin
        epc_vis    = epc_raw;
        epc_vis[0] = 1'b0;
        if (hide_bit1) begin
            epc_vis[1] = 1'b0;
        end
    end

endmodule

// File: rtl/epc_tvec_target.sv
module epc_tvec_target
    import epc_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 6
) (
    input  logic [XLEN-1:0]    tvec,
    input  logic               trap_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    output logic [XLEN-1:0]    trap_target
);

    localparam int unsigned OFS_W = CAUSE_W + VEC_SLOT_SHIFT;

    logic [XLEN-1:0]  base;
    logic [OFS_W-1:0] slot_ofs;
    logic             use_slot;

    always_comb begin
        base     = {tvec[XLEN-1:2], 2'b00};
        slot_ofs = {trap_cause, {VEC_SLOT_SHIFT{1'b0}}};
        use_slot = trap_irq && (tvec[1:0] == TVEC_MODE_VECTORED);
        if (use_slot) begin
            trap_target = base + XLEN'(slot_ofs);
        end else begin
            trap_target = base;
        end
    end

endmodule

// File: rtl/epc_trap_unit.sv
module epc_trap_unit #(
    parameter int unsigned XLEN             = 32,
    parameter bit          ALIGN_SWITCHABLE = 1'b1,
    parameter int unsigned CAUSE_W          = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    input  logic               trap_take,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic               trap_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    tvec,
    input  logic               align32,
    output logic [XLEN-1:0]    ret_pc,
    output logic [XLEN-1:0]    trap_target
);

    logic [XLEN-1:0] epc_raw;
    logic [XLEN-1:0] epc_vis;

    epc_store #(
        .XLEN             (XLEN),
        .ALIGN_SWITCHABLE (ALIGN_SWITCHABLE)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .trap_take (trap_take),
        .trap_pc   (trap_pc),
        .epc_raw   (epc_raw)
    );

    epc_read_mask #(
        .XLEN             (XLEN),
        .ALIGN_SWITCHABLE (ALIGN_SWITCHABLE)
    ) u_mask (
        .epc_raw (epc_raw),
        .align32 (align32),
        .epc_vis (epc_vis)
    );

    epc_tvec_target #(
        .XLEN    (XLEN),
        .CAUSE_W (CAUSE_W)
    ) u_target (
        .tvec        (tvec),
        .trap_irq    (trap_irq),
        .trap_cause  (trap_cause),
        .trap_target (trap_target)
    );

    // CSR read and trap-return read share one masked view
    assign csr_rdata = epc_vis;
    assign ret_pc    = epc_vis;

    // R2: the return address is never odd
    a_r2_ret_even: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_pc[0]);

    // R3: 32-bit alignment hides bit 1 in the switchable configuration
    a_r3_bit1_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        align32 |-> !csr_rdata[1]);

    // R4: the hidden bit 1 reappears when alignment drops to 16 bits
    a_r4_bit1_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ALIGN_SWITCHABLE && !align32) |-> (csr_rdata[1] == epc_raw[1]));

    // R9: synchronous exceptions use the vector with mode bits cleared
    a_r9_sync_base: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_irq |-> ((trap_target[1:0] == 2'b00) &&
                       (trap_target[XLEN-1:2] == tvec[XLEN-1:2])));

endmodule

// File: tb/test_epc_trap_unit.sv
`timescale 1ns/1ps
module test_epc_trap_unit;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned CAUSE_W = 6;
    localparam int          NVEC    = 10;

    // op: 0 CSR write, 1 trap entry, 2 both (trap_pc=data, csr_wdata=~data), 3 idle
    typedef struct packed {
        logic [1:0]      op;
        logic [XLEN-1:0] data;
        logic            al32;
        logic [XLEN-1:0] exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 32'h8000_0003, 1'b0, 32'h8000_0002},  // R2 R3 bit1 visible
        '{2'd3, 32'h0000_0000, 1'b1, 32'h8000_0000},  // R3 hidden
        '{2'd3, 32'h0000_0000, 1'b0, 32'h8000_0002},  // R4 reappears
        '{2'd1, 32'h0000_1235, 1'b0, 32'h0000_1234},  // R7 capture
        '{2'd2, 32'h0000_4446, 1'b0, 32'h0000_4446},  // R8 trap wins
        '{2'd3, 32'h0000_0000, 1'b0, 32'h0000_4446},  // R12 hold
        '{2'd0, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFC},  // R3 hidden on write
        '{2'd3, 32'h0000_0000, 1'b0, 32'hFFFF_FFFE},  // R4 kept
        '{2'd1, 32'h0000_0106, 1'b1, 32'h0000_0104},  // R7 under align32
        '{2'd3, 32'h0000_0000, 1'b0, 32'h0000_0106}   // R4 kept after trap
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               csr_we = 1'b0;
    logic [XLEN-1:0]    csr_wdata = '0;
    logic               trap_take = 1'b0;
    logic [XLEN-1:0]    trap_pc = '0;
    logic               trap_irq = 1'b0;
    logic [CAUSE_W-1:0] trap_cause = '0;
    logic [XLEN-1:0]    tvec = '0;
    logic               align32 = 1'b0;
    logic [XLEN-1:0]    csr_rdata, ret_pc, trap_target;
    logic [XLEN-1:0]    csr_rdata_f, ret_pc_f, trap_target_f;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    epc_trap_unit #(.XLEN(XLEN), .ALIGN_SWITCHABLE(1'b1), .CAUSE_W(CAUSE_W)) i_epc_trap_unit (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .trap_take(trap_take), .trap_pc(trap_pc),
        .trap_irq(trap_irq), .trap_cause(trap_cause), .tvec(tvec),
        .align32(align32), .ret_pc(ret_pc), .trap_target(trap_target)
    );

    epc_trap_unit #(.XLEN(XLEN), .ALIGN_SWITCHABLE(1'b0), .CAUSE_W(CAUSE_W)) i_epc_trap_unit_fixed (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata_f), .trap_take(trap_take), .trap_pc(trap_pc),
        .trap_irq(trap_irq), .trap_cause(trap_cause), .tvec(tvec),
        .align32(align32), .ret_pc(ret_pc_f), .trap_target(trap_target_f)
    );

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic target_case(input logic [XLEN-1:0] tv, input logic irq,
                               input logic [CAUSE_W-1:0] cause,
                               input logic [XLEN-1:0] exp, input string req);
        @(negedge clk);
        tvec = tv; trap_irq = irq; trap_cause = cause;
        #1;
        check(req, trap_target, exp);
        check(req, trap_target_f, exp);
    endtask

    initial begin
        // R1: reset state
        #1;
        check("R1 rdata in reset", csr_rdata, '0);
        check("R1 ret_pc in reset", ret_pc, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 rdata after reset", csr_rdata, '0);
        check("R1 ret_pc after reset", ret_pc, '0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            align32 = VECS[i].al32;
            case (VECS[i].op)
                2'd0: begin csr_we = 1'b1; csr_wdata = VECS[i].data; end
                2'd1: begin trap_take = 1'b1; trap_pc = VECS[i].data; end
                2'd2: begin
                    csr_we = 1'b1; csr_wdata = ~VECS[i].data;
                    trap_take = 1'b1; trap_pc = VECS[i].data;
                end
                default: ;
            endcase
            @(negedge clk);
            csr_we = 1'b0; trap_take = 1'b0;
            #1;
            check($sformatf("R2/R3/R4/R7/R8/R12 vec %0d rdata", i), csr_rdata, VECS[i].exp);
            check($sformatf("R6 vec %0d ret_pc", i), ret_pc, VECS[i].exp);
            check($sformatf("R5 vec %0d fixed rdata", i), csr_rdata_f, VECS[i].exp & ~32'h3);
            check($sformatf("R5 vec %0d fixed ret_pc", i), ret_pc_f, VECS[i].exp & ~32'h3);
        end

        // R5: fixed configuration ignores align32 = 0
        @(negedge clk);
        align32 = 1'b0; csr_we = 1'b1; csr_wdata = 32'h0000_00F7;
        @(negedge clk);
        csr_we = 1'b0; #1;
        check("R5 fixed low bits", csr_rdata_f, 32'h0000_00F4);
        check("R2 switchable bit0", csr_rdata, 32'h0000_00F6);

        // R9, R10, R11: trap target
        target_case(32'h8000_0101, 1'b0, 6'd5,  32'h8000_0100, "R9 sync vectored");
        target_case(32'h8000_0102, 1'b0, 6'd9,  32'h8000_0100, "R9 sync mode2");
        target_case(32'h8000_0101, 1'b1, 6'd5,  32'h8000_0114, "R10 irq vectored");
        target_case(32'h0000_1001, 1'b1, 6'd63, 32'h0000_10FC, "R10 irq max cause");
        target_case(32'h8000_0100, 1'b1, 6'd5,  32'h8000_0100, "R11 irq direct");
        target_case(32'h8000_0103, 1'b1, 6'd7,  32'h8000_0100, "R11 irq mode3");
        target_case(32'h8000_0102, 1'b1, 6'd7,  32'h8000_0100, "R11 irq mode2");

        // R1: reset mid-run clears the register
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = 32'h1234_5678;
        @(negedge clk);
        csr_we = 1'b0;
        rst_n = 1'b0; #1;
        check("R1 reset mid-run", csr_rdata, '0);
        check("R1 reset mid-run ret", ret_pc, '0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule